// File: doc/BRIEF.md
# Width-Narrowing Dual-Clock FIFO

This block carries data from one clock domain to another while cutting the data width. Writers present wide words on the write clock. Readers pull narrow slices on an unrelated read clock. The wide width is a power-of-two multiple of the narrow width, and that multiple must be at least two. Each accepted wide word lands in storage that is addressed in narrow units, so the read side can walk through it one slice per read.

A parameter sets which end of the wide word comes out first. Another parameter chooses between two output modes. In fall-through mode the oldest slice is already on `dout` whenever `empty` is low. In registered mode a slice appears on `dout` one read clock after an accepted read. Read and write positions cross between the domains in Gray code. Flags that depend on the far side's position react late, so they err on the safe side: a flag may report less room or less data than there really is, but never more.

Each reset is active-high and acts asynchronously. The two resets may be tied together or driven separately.

Top module: `narrowing_async_fifo`

## Requirements
- R1: Each accepted wide word is delivered as IN_W/OUT_W slices, and words come out in the order they were written. With HI_FIRST=1, bits [IN_W-1 -: OUT_W] come out first and bits [OUT_W-1:0] come out last. With HI_FIRST=0, the order runs from the low bits upward.
- R2: The block holds 2**WADDR_W wide words. With the read side idle, `full` is high once exactly that many writes have been accepted.
- R3: A write attempted while `full` is high is dropped. No data from it ever reaches `dout`.
- R4: A read attempted while `empty` is high is dropped. It does not move the read position, and in registered mode `dout` keeps its value.
- R5: A wide slot becomes free only after its last slice has been read. When some of a word's slices have been read but not all of them, `full` does not fall.
- R6: `almost_full` is high when one wide slot or none is free.
- R7: `almost_empty` is high when the read side sees one stored slice or none.
- R8: With FWFT=1, `dout` shows the oldest stored slice whenever `empty` is low, and `rd_en` moves to the next one. With FWFT=0, `dout` changes only on the read clock edge after an accepted read.
- R9: Positions cross the clock domains in Gray code through two-stage synchronisers. `empty` never falls without stored data, and `full` never falls without a free slot. Once both sides have been idle for a few cycles, every flag matches the true occupancy.
- R10: After reset, `empty` and `almost_empty` are high, `full` and `almost_full` are low, and in registered mode `dout` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| wr_rst | input | 1 | Asynchronous active-high reset of the write side |
| din | input | IN_W | Wide word to store |
| wr_en | input | 1 | Write request |
| full | output | 1 | No wide slot free |
| almost_full | output | 1 | At most one wide slot free |
| rd_clk | input | 1 | Read clock |
| rd_rst | input | 1 | Asynchronous active-high reset of the read side |
| rd_en | input | 1 | Read request |
| dout | output | OUT_W | Narrow slice output |
| empty | output | 1 | No slice available |
| almost_empty | output | 1 | At most one slice available |

## Verification
The bench builds two instances with a 16-bit input, a 4-bit output and a write address width of 3. That gives 8 wide slots and a 5-bit read address. One instance takes the high slice first and runs in fall-through mode. The other takes the low slice first and uses a registered output, so both slice orders and both output modes are covered by the same stimulus. The shallow depth makes it cheap to reach the full boundary, the almost-full boundary and a half-read slot that still blocks `full`. The clock periods of 10 and 14 keep the two domains sliding past each other throughout random concurrent traffic.

// File: rtl/narrowing_async_fifo.sv
module narrowing_async_fifo #(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 4,
  parameter int WADDR_W  = 3,
  parameter bit HI_FIRST = 1'b1,
  parameter bit FWFT     = 1'b0
) (
  input  logic             wr_clk,
  input  logic             wr_rst,
  input  logic [IN_W-1:0]  din,
  input  logic             wr_en,
  output logic             full,
  output logic             almost_full,
  input  logic             rd_clk,
  input  logic             rd_rst,
  input  logic             rd_en,
  output logic [OUT_W-1:0] dout,
  output logic             empty,
  output logic             almost_empty
);
  localparam int RATIO   = IN_W / OUT_W;
  localparam int SW      = $clog2(RATIO);
  localparam int RADDR_W = WADDR_W + SW;
  localparam int DEPTH   = 1 << WADDR_W;
  localparam int SLOTS   = 1 << RADDR_W;
  localparam int AW      = WADDR_W + 1;
  localparam int RW      = RADDR_W + 1;

  logic [OUT_W-1:0] mem [SLOTS];

  logic [AW-1:0] wbin, wgray, wq1, wq2, wq_bin, wcount;
  logic [RW-1:0] rbin, rgray, rq1, rq2, rq_bin, rcount;

  wire          wr_ok = wr_en && !full;
  wire          rd_ok = rd_en && !empty;
  wire [AW-1:0] wnext = wbin + 1'b1;
  wire [RW-1:0] rnext = rbin + 1'b1;

  // write domain
  always_ff @(posedge wr_clk or posedge wr_rst) begin
    if (wr_rst) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_ok) begin
        wbin  <= wnext;
        wgray <= wnext ^ (wnext >> 1);
      end
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_ok) begin
      for (int k = 0; k < RATIO; k++) begin
        if (HI_FIRST)
          mem[{wbin[WADDR_W-1:0], SW'(k)}] <= din[IN_W-1-k*OUT_W -: OUT_W];
        else
          mem[{wbin[WADDR_W-1:0], SW'(k)}] <= din[k*OUT_W +: OUT_W];
      end
    end
  end

  // read domain
  always_ff @(posedge rd_clk or posedge rd_rst) begin
    if (rd_rst) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (rd_ok) begin
        rbin  <= rnext;
        rgray <= rnext ^ (rnext >> 1);
      end
    end
  end

  for (genvar i = 0; i < RW; i++) begin : g_rq
    assign rq_bin[i] = ^rq2[RW-1:i];
  end
  for (genvar i = 0; i < AW; i++) begin : g_wq
    assign wq_bin[i] = ^wq2[AW-1:i];
  end

  assign wcount       = wbin - rq_bin[RW-1:SW];
  assign full         = (wcount == AW'(DEPTH));
  assign almost_full  = (wcount >= AW'(DEPTH - 1));
  assign rcount       = {wq_bin, {SW{1'b0}}} - rbin;
  assign empty        = (rcount == '0);
  assign almost_empty = (rcount <= RW'(1));

  if (FWFT) begin : g_fwft
    assign dout = mem[rbin[RADDR_W-1:0]];
  end else begin : g_std
    logic [OUT_W-1:0] dout_q;
    always_ff @(posedge rd_clk or posedge rd_rst) begin
      if (rd_rst)     dout_q <= '0;
      else if (rd_ok) dout_q <= mem[rbin[RADDR_W-1:0]];
    end
    assign dout = dout_q;
  end
endmodule

// File: rtl/narrowing_async_fifo_checks.sv
module narrowing_async_fifo_checks #(
  parameter int AW    = 4,
  parameter int RW    = 6,
  parameter int OUT_W = 4,
  parameter bit FWFT  = 1'b0
) (
  input logic             wr_clk,
  input logic             wr_rst,
  input logic             wr_en,
  input logic             full,
  input logic             almost_full,
  input logic [AW-1:0]    wbin,
  input logic [AW-1:0]    wgray,
  input logic             rd_clk,
  input logic             rd_rst,
  input logic             rd_en,
  input logic             empty,
  input logic             almost_empty,
  input logic [RW-1:0]    rbin,
  input logic [RW-1:0]    rgray,
  input logic [OUT_W-1:0] dout
);
  assert_no_overflow_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_en && full |=> wbin == $past(wbin));

  assert_no_underflow_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_en && empty |=> rbin == $past(rbin));

  assert_full_implies_almost_R6: assert property (@(posedge wr_clk) disable iff (wr_rst)
    full |-> almost_full);

  assert_empty_implies_almost_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    empty |-> almost_empty);

  assert_wgray_one_step_R9: assert property (@(posedge wr_clk) disable iff (wr_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_one_step_R9: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $countones(rgray ^ $past(rgray)) <= 1);

  assert_dout_held_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    !empty && !rd_en |=> $stable(dout));

  if (!FWFT) begin : g_std
    assert_dout_held_empty_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
      empty |=> $stable(dout));
  end
endmodule

bind narrowing_async_fifo narrowing_async_fifo_checks #(
  .AW(AW), .RW(RW), .OUT_W(OUT_W), .FWFT(FWFT)
) chk_i (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .full(full),
  .almost_full(almost_full), .wbin(wbin), .wgray(wgray),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .empty(empty),
  .almost_empty(almost_empty), .rbin(rbin), .rgray(rgray), .dout(dout)
);

// File: tb/narrowing_async_fifo_tb_top.sv
module narrowing_async_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int IN_W       = 16;
  localparam int OUT_W      = 4;
  localparam int WADDR_W    = 3;
  localparam int RATIO      = IN_W / OUT_W;
  localparam int DEPTH      = 1 << WADDR_W;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1, wr_en = 0, rd_en = 0;
  logic [IN_W-1:0] din = '0;
  logic full_a, afull_a, empty_a, aempty_a, full_b, afull_b, empty_b, aempty_b;
  logic [OUT_W-1:0] dout_a, dout_b;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  narrowing_async_fifo #(.IN_W(IN_W), .OUT_W(OUT_W), .WADDR_W(WADDR_W),
    .HI_FIRST(1'b1), .FWFT(1'b1)) dut_i (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .din(din), .wr_en(wr_en), .full(full_a),
    .almost_full(afull_a), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .dout(dout_a), .empty(empty_a), .almost_empty(aempty_a));

  narrowing_async_fifo #(.IN_W(IN_W), .OUT_W(OUT_W), .WADDR_W(WADDR_W),
    .HI_FIRST(1'b0), .FWFT(1'b0)) dut_s (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .din(din), .wr_en(wr_en), .full(full_b),
    .almost_full(afull_b), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .dout(dout_b), .empty(empty_b), .almost_empty(aempty_b));

  logic [OUT_W-1:0] q_a[$], q_b[$];
  int words_a = 0, words_b = 0, pop_a = 0, pop_b = 0;
  int checks = 0, fails = 0;
  bit pend_b = 0, done = 0;
  logic [OUT_W-1:0] exp_b;
  string pend_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic write_word(input logic [IN_W-1:0] d, input bit en);
    @(negedge wr_clk);
    wr_en = en;
    din   = d;
    if (!full_a) chk((words_a - pop_a/RATIO) < DEPTH, "R9", "full low without room", words_a, DEPTH);
    if (en && !full_a) begin
      for (int k = 0; k < RATIO; k++) q_a.push_back(d[IN_W-1-k*OUT_W -: OUT_W]);
      words_a++;
    end
    if (en && !full_b) begin
      for (int k = 0; k < RATIO; k++) q_b.push_back(d[k*OUT_W +: OUT_W]);
      words_b++;
    end
  endtask

  task automatic read_slice(input bit en);
    @(negedge rd_clk);
    if (pend_b) chk(dout_b == exp_b, pend_tag, "registered dout", dout_b, exp_b);
    rd_en = en;
    if (!empty_a) begin
      if (q_a.size() == 0) chk(0, "R9", "fall-through empty low with no data", 0, 1);
      else begin
        chk(dout_a == q_a[0], "R1 R8", "fall-through dout", dout_a, q_a[0]);
        if (en) begin void'(q_a.pop_front()); pop_a++; end
      end
    end
    if (!empty_b && q_b.size() == 0) chk(0, "R9", "registered empty low with no data", 0, 1);
    if (en && !empty_b && q_b.size() > 0) begin
      exp_b = q_b.pop_front();
      pop_b++;
      pend_tag = "R1";
    end else begin
      exp_b = dout_b;
      pend_tag = (en && empty_b) ? "R4" : "R8";
    end
    pend_b = 1;
  endtask

  task automatic settle(input string tag);
    int occ_a, occ_b;
    repeat (6) @(negedge rd_clk);
    repeat (6) @(negedge wr_clk);
    occ_a = words_a - pop_a/RATIO;
    occ_b = words_b - pop_b/RATIO;
    chk(empty_a == (q_a.size() == 0), "R9", {tag, " empty_a"}, empty_a, q_a.size() == 0);
    chk(empty_b == (q_b.size() == 0), "R9", {tag, " empty_b"}, empty_b, q_b.size() == 0);
    chk(aempty_a == (q_a.size() <= 1), "R7", {tag, " almost_empty_a"}, aempty_a, q_a.size() <= 1);
    chk(aempty_b == (q_b.size() <= 1), "R7", {tag, " almost_empty_b"}, aempty_b, q_b.size() <= 1);
    chk(full_a == (occ_a == DEPTH), "R2", {tag, " full_a"}, full_a, occ_a == DEPTH);
    chk(full_b == (occ_b == DEPTH), "R2", {tag, " full_b"}, full_b, occ_b == DEPTH);
    chk(afull_a == (occ_a >= DEPTH-1), "R6", {tag, " almost_full_a"}, afull_a, occ_a >= DEPTH-1);
    chk(afull_b == (occ_b >= DEPTH-1), "R6", {tag, " almost_full_b"}, afull_b, occ_b >= DEPTH-1);
  endtask

  task automatic drain();
    int n;
    n = q_a.size();
    for (int i = 0; i < n; i++) read_slice(1);
    read_slice(0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    wr_rst = 0;
    @(negedge rd_clk);
    rd_rst = 0;
    @(negedge wr_clk);
    // R10 reset state
    chk(empty_a && empty_b, "R10", "empty after reset", {empty_a, empty_b}, 2'b11);
    chk(aempty_a && aempty_b, "R10", "almost_empty after reset", {aempty_a, aempty_b}, 2'b11);
    chk(!full_a && !full_b, "R10", "full after reset", {full_a, full_b}, 0);
    chk(!afull_a && !afull_b, "R10", "almost_full after reset", {afull_a, afull_b}, 0);
    chk(dout_b == '0, "R10", "registered dout after reset", dout_b, 0);

    // R1 basic ordering, three words
    write_word(16'hA1B2, 1);
    write_word(16'hC3D4, 1);
    write_word(16'hE5F6, 1);
    write_word('0, 0);
    settle("three words");
    drain();
    settle("after drain");

    // R4 reads while empty
    read_slice(1);
    read_slice(1);
    read_slice(0);
    settle("read on empty");

    // R2 R3 R6 fill past capacity
    for (int i = 0; i < DEPTH + 2; i++) begin
      write_word((i >= DEPTH) ? 16'hDEAD : IN_W'(16'h1000 * i + 16'h0123 * (i + 1)), 1);
      chk(full_a == (i >= DEPTH), "R2", "full during fill", full_a, i >= DEPTH);
      chk(afull_a == (i >= DEPTH - 1), "R6", "almost_full during fill", afull_a, i >= DEPTH - 1);
    end
    write_word('0, 0);
    settle("filled");

    // R5 partial word keeps the slot
    for (int i = 0; i < RATIO - 1; i++) read_slice(1);
    read_slice(0);
    settle("partial word");
    chk(full_a == 1'b1, "R5", "full with partly read word", full_a, 1);
    read_slice(1);
    read_slice(0);
    settle("word retired");
    chk(full_a == 1'b0 && afull_a == 1'b1, "R5", "flags after last slice", {full_a, afull_a}, 2'b01);

    // R7 one slice left
    begin
      int n;
      n = q_a.size();
      for (int i = 0; i < n - 1; i++) read_slice(1);
      read_slice(0);
    end
    settle("one slice left");
    chk(aempty_a && !empty_a, "R7", "almost_empty with one slice", {aempty_a, empty_a}, 2'b10);
    read_slice(1);
    read_slice(1);
    read_slice(0);
    settle("empty again");

    // R9 concurrent random traffic
    fork
      begin
        for (int i = 0; i < 80; i++) write_word(IN_W'($urandom), ($urandom % 10) < 7);
        write_word('0, 0);
      end
      begin
        for (int i = 0; i < 300; i++) read_slice(($urandom % 10) < 6);
        read_slice(0);
      end
    join
    settle("after traffic");
    drain();
    settle("final");
    read_slice(0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule